// File: doc/BRIEF.md
# Banked Data-Memory Access Path

This block is the data-memory access path of a small 8-bit core. Each core-side access carries an 8-bit address, an operation (read, write, bit set or bit clear) and, for bit operations, a bit index. The block turns the address into a target:
- one of its own pointer registers,
- an external special-register block,
- an external control-register block,
- a reserved hole,
- or one byte of banked general RAM, which the block holds itself.

Two addresses act as indirect windows. Address 00H reaches the location held in the first pointer register, always in bank 0. Address 02H reaches the location held in the second pointer register, in the bank named by a bank-select register. Direct accesses and first-pointer accesses never leave bank 0, so the upper banks can only be reached through the second window. A bank-select value with no bank behind it turns RAM accesses into reads of zero with no write. An indirect window that points at either window address is a null access.

Bit set and bit clear are read-modify-write operations that finish in the same cycle. For the external blocks, the block drives a select, a 5-bit offset and a write strobe. It expects read data back from them in the same cycle. Read results come out registered, one cycle after the request.

Top module: `dmem_access`

## Requirements
- R1: Resolved location 05H–1FH drives `ext_sfr_sel`, and 20H–`ECR_LAST` drives `ext_ecr_sel`. In both cases `ext_addr` equals the location's low five bits and `ext_we` is high for every non-read operation. At most one select is ever high.
- R2: Locations from `ECR_LAST`+1 up to 3FH are reserved. They read 00H, ignore writes and bit operations, and raise no external select.
- R3: A direct access to 40H–FFH always uses RAM bank 0, whatever the bank-select register holds.
- R4: An access to address 00H targets the location held in pointer register A (address 01H). Any RAM it reaches is in bank 0.
- R5: An access to address 02H targets the location held in pointer register B (address 03H). Any RAM it reaches is in the bank given by the bank-select register (address 04H). For non-RAM targets, bank-select has no effect.
- R6: When bank-select is `NUM_BANKS` or greater, RAM accesses through 02H read 00H and leave every bank unchanged.
- R7: When the window in use holds a pointer of 00H or 02H, the access reads 00H and changes no register, RAM byte or external register.
- R8: Operation code 2 sets, and code 3 clears, bit `acc_bit` of the target. Every other bit stays as it was, and the new value is in place at the next clock.
- R9: A read (operation code 0) with `acc_en` high gives `rd_valid` high and the pre-access value on `rd_data` one cycle later. In every other cycle `rd_valid` is low. Code 1 is a plain write of `acc_wdata`.
- R10: After reset, pointer A, pointer B and bank-select are 00H, and `rd_valid` and `rd_data` are 0.
- R11: Locations 01H, 03H and 04H are the block's own pointer and bank-select registers. They can be read and written directly or through a window, and they raise no external select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request this cycle |
| acc_op | input | 2 | 0 read, 1 write, 2 bit set, 3 bit clear |
| acc_addr | input | 8 | Core-side data address |
| acc_wdata | input | 8 | Write data for code 1 |
| acc_bit | input | 3 | Bit index for codes 2 and 3 |
| rd_valid | output | 1 | Registered read-data valid |
| rd_data | output | 8 | Registered read data |
| ext_sfr_sel | output | 1 | External special-register block selected |
| ext_ecr_sel | output | 1 | External control-register block selected |
| ext_addr | output | 5 | Offset within the selected external block |
| ext_we | output | 1 | Write strobe to the selected external block |
| ext_wdata | output | 8 | Write data (already bit-modified) |
| ext_rdata | input | 8 | Same-cycle read data from the selected external block |

## Verification
The following are checked by assertions on every cycle:
- the one-hot external selects, and that `ext_we` never rises without a select;
- that RAM writes never address a missing bank;
- that direct RAM accesses land in bank 0;
- that null window accesses and reserved addresses write nothing;
- that an external bit operation differs from the old value in at most one bit;
- the read-valid timing;
- that the pointer registers hold when not written.

Only the bench's scenarios can show that data actually round-trips to the right bank and register. This covers bank isolation under an out-of-range bank-select, windows aimed at the pointer registers themselves, and the reset values read back through the port.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int DW = 8;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_SET = 2'd2,
    OP_CLR = 2'd3
  } dm_op_e;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_PTR  = 3'd1,
    RG_SFR  = 3'd2,
    RG_ECR  = 3'd3,
    RG_RAM  = 3'd4
  } dm_region_e;

  // Value to store for a modifying operation, given the current contents.
  function automatic logic [DW-1:0] dm_apply(input dm_op_e op,
                                             input logic [DW-1:0] cur,
                                             input logic [DW-1:0] wd,
                                             input logic [2:0] idx);
    logic [DW-1:0] mask;
    mask = DW'(1) << idx;
    case (op)
      OP_WR:   dm_apply = wd;
      OP_SET:  dm_apply = cur | mask;
      OP_CLR:  dm_apply = cur & ~mask;
      default: dm_apply = cur;
    endcase
  endfunction

endpackage

// File: rtl/dmem_ptr_regs.sv
module dmem_ptr_regs
  import dmem_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_loc,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ptr_a,
  output logic [DW-1:0] ptr_b,
  output logic [DW-1:0] bank_sel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_a    <= '0;
      ptr_b    <= '0;
      bank_sel <= '0;
    end else if (wr_en) begin
      case (wr_loc)
        8'h01:   ptr_a    <= wr_data;
        8'h03:   ptr_b    <= wr_data;
        8'h04:   bank_sel <= wr_data;
        default: ;
      endcase
    end
  end

  // R11: without a write strobe the pointer registers keep their value
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(ptr_a) && $stable(ptr_b) && $stable(bank_sel)));

endmodule

// File: rtl/dmem_resolve.sv
module dmem_resolve
  import dmem_pkg::*;
#(
  parameter int          NUM_BANKS = 4,
  parameter logic [7:0]  ECR_LAST  = 8'h2F,
  localparam int         BK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [DW-1:0]   addr,
  input  logic [DW-1:0]   ptr_a,
  input  logic [DW-1:0]   ptr_b,
  input  logic [DW-1:0]   bank_sel,
  output dm_region_e      region,
  output logic [DW-1:0]   loc,
  output logic [BK_W-1:0] bank_idx,
  output logic            self_ref
);

  localparam logic [DW-1:0] WIN_A    = 8'h00;
  localparam logic [DW-1:0] WIN_B    = 8'h02;
  localparam logic [DW-1:0] RAM_BASE = 8'h40;
  localparam logic [DW-1:0] SFR_EXT  = 8'h05;
  localparam logic [DW-1:0] ECR_BASE = 8'h20;

  logic          via_a, via_b;
  logic [DW-1:0] bank_full;
  logic          bank_ok;

  always_comb begin
    via_a     = (addr == WIN_A);
    via_b     = (addr == WIN_B);
    loc       = via_a ? ptr_a : (via_b ? ptr_b : addr);
    self_ref  = (via_a || via_b) && ((loc == WIN_A) || (loc == WIN_B));
    bank_full = via_b ? bank_sel : '0;
    bank_ok   = ({1'b0, bank_full} < 9'(NUM_BANKS));
    bank_idx  = bank_full[BK_W-1:0];

    if (self_ref)                              region = RG_NONE;
    else if (loc >= RAM_BASE)                  region = bank_ok ? RG_RAM : RG_NONE;
    else if (loc < ECR_BASE) begin
      if (loc == 8'h01 || loc == 8'h03 || loc == 8'h04) region = RG_PTR;
      else if (loc >= SFR_EXT)                 region = RG_SFR;
      else                                     region = RG_NONE;
    end
    else if (loc <= ECR_LAST)                  region = RG_ECR;
    else                                       region = RG_NONE;
  end

endmodule

// File: rtl/dmem_bank_ram.sv
module dmem_bank_ram
  import dmem_pkg::*;
#(
  parameter int  NUM_BANKS = 4,
  localparam int BK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int WORDS     = 256 - 64
) (
  input  logic            clk,
  input  logic            we,
  input  logic [BK_W-1:0] bank,
  input  logic [DW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);

  logic [DW-1:0] off;
  logic [DW-1:0] rd_bank [NUM_BANKS];

  assign off = addr - 8'h40;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DW-1:0] mem [0:WORDS-1];
    always_ff @(posedge clk) begin
      if (we && (bank == BK_W'(b))) mem[off] <= wdata;
    end
    assign rd_bank[b] = mem[off];
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank == BK_W'(b)) rdata = rd_bank[b];
    end
  end

  // R6: a write strobe never reaches a bank that does not exist
  a_r6_bank_exists: assert property (@(posedge clk)
    we |-> (int'(bank) < NUM_BANKS));

endmodule

// File: rtl/dmem_access.sv
module dmem_access
  import dmem_pkg::*;
#(
  parameter int         NUM_BANKS = 4,
  parameter logic [7:0] ECR_LAST  = 8'h2F,
  localparam int        BK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_en,
  input  logic [1:0] acc_op,
  input  logic [7:0] acc_addr,
  input  logic [7:0] acc_wdata,
  input  logic [2:0] acc_bit,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       ext_sfr_sel,
  output logic       ext_ecr_sel,
  output logic [4:0] ext_addr,
  output logic       ext_we,
  output logic [7:0] ext_wdata,
  input  logic [7:0] ext_rdata
);

  dm_op_e          op;
  dm_region_e      region;
  logic [DW-1:0]   loc;
  logic [BK_W-1:0] bank_idx;
  logic            self_ref;
  logic [DW-1:0]   ptr_a, ptr_b, bank_sel;
  logic [DW-1:0]   ram_rdata, cur_val, new_val;
  logic            modify, ram_we, ptr_we, is_read;

  assign op = dm_op_e'(acc_op);

  dmem_ptr_regs u_ptr (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ptr_we),
    .wr_loc   (loc),
    .wr_data  (new_val),
    .ptr_a    (ptr_a),
    .ptr_b    (ptr_b),
    .bank_sel (bank_sel)
  );

  dmem_resolve #(.NUM_BANKS(NUM_BANKS), .ECR_LAST(ECR_LAST)) u_res (
    .addr     (acc_addr),
    .ptr_a    (ptr_a),
    .ptr_b    (ptr_b),
    .bank_sel (bank_sel),
    .region   (region),
    .loc      (loc),
    .bank_idx (bank_idx),
    .self_ref (self_ref)
  );

  dmem_bank_ram #(.NUM_BANKS(NUM_BANKS)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .bank  (bank_idx),
    .addr  (loc),
    .wdata (new_val),
    .rdata (ram_rdata)
  );

  always_comb begin
    case (region)
      RG_PTR:         cur_val = (loc == 8'h01) ? ptr_a : ((loc == 8'h03) ? ptr_b : bank_sel);
      RG_SFR, RG_ECR: cur_val = ext_rdata;
      RG_RAM:         cur_val = ram_rdata;
      default:        cur_val = '0;
    endcase
    new_val     = dm_apply(op, cur_val, acc_wdata, acc_bit);
    is_read     = acc_en && (op == OP_RD);
    modify      = acc_en && (op != OP_RD);
    ext_sfr_sel = acc_en && (region == RG_SFR);
    ext_ecr_sel = acc_en && (region == RG_ECR);
    ext_addr    = loc[4:0];
    ext_we      = modify && ((region == RG_SFR) || (region == RG_ECR));
    ext_wdata   = new_val;
    ram_we      = modify && (region == RG_RAM);
    ptr_we      = modify && (region == RG_PTR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= is_read;
      if (is_read) rd_data <= cur_val;
    end
  end

  // R1: external selects are mutually exclusive
  a_r1_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ext_sfr_sel, ext_ecr_sel}));

  // R1: an external write always comes with a select
  a_r1_we_has_sel: assert property (@(posedge clk) disable iff (rst)
    ext_we |-> (ext_sfr_sel || ext_ecr_sel));

  // R2: the reserved hole drives nothing
  a_r2_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (acc_en && (acc_addr > ECR_LAST) && (acc_addr < 8'h40))
      |-> (!ext_sfr_sel && !ext_ecr_sel && !ram_we && !ptr_we));

  // R3: direct RAM accesses stay in bank 0
  a_r3_direct_bank0: assert property (@(posedge clk) disable iff (rst)
    (acc_en && (acc_addr >= 8'h40)) |-> ((bank_idx == '0) && (region == RG_RAM)));

  // R7: a window aimed at a window writes nothing
  a_r7_self_ref_inert: assert property (@(posedge clk) disable iff (rst)
    (acc_en && (((acc_addr == 8'h00) && ((ptr_a == 8'h00) || (ptr_a == 8'h02))) ||
                ((acc_addr == 8'h02) && ((ptr_b == 8'h00) || (ptr_b == 8'h02)))))
      |-> (!ext_we && !ram_we && !ptr_we));

  // R8: an external bit operation flips at most one bit
  a_r8_single_bit: assert property (@(posedge clk) disable iff (rst)
    (ext_we && (acc_op[1] == 1'b1)) |-> ($countones(ext_wdata ^ ext_rdata) <= 1));

  // R9: read data valid exactly one cycle after a read request
  a_r9_read_valid: assert property (@(posedge clk) disable iff (rst)
    (acc_en && (acc_op == 2'd0)) |=> rd_valid);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !(acc_en && (acc_op == 2'd0)) |=> !rd_valid);

endmodule

// File: tb/dmem_access_tb.sv
module dmem_access_tb;
  import dmem_pkg::*;

  localparam int         NB   = 4;
  localparam logic [7:0] ELST = 8'h2F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic       acc_en = 1'b0;
  logic [1:0] acc_op = 2'd0;
  logic [7:0] acc_addr = '0, acc_wdata = '0;
  logic [2:0] acc_bit = '0;
  logic       rd_valid, ext_sfr_sel, ext_ecr_sel, ext_we;
  logic [7:0] rd_data, ext_wdata, ext_rdata;
  logic [4:0] ext_addr;

  always #2 clk = ~clk;

  dmem_access #(.NUM_BANKS(NB), .ECR_LAST(ELST)) u_dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_op(acc_op), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_bit(acc_bit), .rd_valid(rd_valid), .rd_data(rd_data),
    .ext_sfr_sel(ext_sfr_sel), .ext_ecr_sel(ext_ecr_sel), .ext_addr(ext_addr),
    .ext_we(ext_we), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  // External register blocks (environment)
  logic [7:0] env_reg [0:63];
  assign ext_rdata = (ext_sfr_sel || ext_ecr_sel) ? env_reg[{ext_ecr_sel, ext_addr}] : 8'h00;
  always @(posedge clk) if (ext_we) env_reg[{ext_ecr_sel, ext_addr}] <= ext_wdata;

  // Reference model state
  logic [7:0] m_ram [0:NB-1][0:255];
  logic [7:0] m_ext [0:63];
  logic [7:0] m_pa = 0, m_pb = 0, m_bs = 0;

  int errors = 0, checks = 0;
  string cur_req = "R10";

  logic  pend_valid = 0, exp_valid = 0;
  logic [7:0] pend_data = 0, exp_data = 0;
  string pend_req = "R9", exp_req = "R9";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    exp_valid <= rst ? 1'b0 : pend_valid;
    exp_data  <= pend_data;
    exp_req   <= pend_req;
  end

  // Cycle-by-cycle comparison of the read port
  always @(negedge clk) begin
    if (!rst) begin
      chk(rd_valid == exp_valid, (exp_valid ? exp_req : "R9"), "rd_valid", rd_valid, exp_valid);
      if (exp_valid) chk(rd_data == exp_data, exp_req, "rd_data", rd_data, exp_data);
    end
  end

  task automatic acc(input dm_op_e op, input logic [7:0] addr, input logic [7:0] wd, input int bi);
    logic ind, nul, esfr, eecr, wrok;
    logic [7:0] p, old, nv, m;
    int bk;
    @(negedge clk);
    acc_en = 1'b1; acc_op = op; acc_addr = addr; acc_wdata = wd; acc_bit = 3'(bi);
    ind = (addr == 8'h00) || (addr == 8'h02);
    p   = (addr == 8'h00) ? m_pa : ((addr == 8'h02) ? m_pb : addr);
    bk  = (addr == 8'h02) ? int'(m_bs) : 0;
    nul = ind && ((p == 8'h00) || (p == 8'h02));
    esfr = !nul && (p >= 8'h05) && (p < 8'h20);
    eecr = !nul && (p >= 8'h20) && (p <= ELST);
    if (nul) old = 0;
    else if (p >= 8'h40) old = (bk < NB) ? m_ram[bk][p] : 8'h00;
    else if (p == 8'h01) old = m_pa;
    else if (p == 8'h03) old = m_pb;
    else if (p == 8'h04) old = m_bs;
    else if (esfr || eecr) old = m_ext[p[5:0]];
    else old = 0;
    m  = 8'h01 << bi;
    nv = (op == OP_WR) ? wd : (op == OP_SET) ? (old | m) : (op == OP_CLR) ? (old & ~m) : old;
    wrok = !nul && (op != OP_RD) &&
           ((p >= 8'h40) ? (bk < NB) : (p == 8'h01 || p == 8'h03 || p == 8'h04 || esfr || eecr));
    pend_valid = (op == OP_RD);
    if (op == OP_RD) pend_data = old;
    pend_req = cur_req;
    #1;
    chk(ext_sfr_sel == esfr, "R1", "ext_sfr_sel", ext_sfr_sel, esfr);
    chk(ext_ecr_sel == eecr, "R1", "ext_ecr_sel", ext_ecr_sel, eecr);
    chk(ext_we == ((esfr || eecr) && op != OP_RD), cur_req, "ext_we", ext_we, (esfr || eecr) && op != OP_RD);
    if (esfr || eecr) begin
      chk(ext_addr == p[4:0], "R1", "ext_addr", ext_addr, p[4:0]);
      if (op != OP_RD) chk(ext_wdata == nv, cur_req, "ext_wdata", ext_wdata, nv);
    end
    if (wrok) begin
      if (p >= 8'h40) m_ram[bk][p] = nv;
      else if (p == 8'h01) m_pa = nv;
      else if (p == 8'h03) m_pb = nv;
      else if (p == 8'h04) m_bs = nv;
      else m_ext[p[5:0]] = nv;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    acc_en = 1'b0; pend_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin env_reg[i] = 8'h00; m_ext[i] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(rd_valid == 1'b0, "R10", "rd_valid after reset", rd_valid, 0);
    chk(rd_data == 8'h00, "R10", "rd_data after reset", rd_data, 0);
    cur_req = "R10";
    acc(OP_RD, 8'h01, 0, 0); acc(OP_RD, 8'h03, 0, 0); acc(OP_RD, 8'h04, 0, 0);

    // Fill every bank through window B
    cur_req = "R5";
    for (int b = 0; b < NB; b++) begin
      acc(OP_WR, 8'h04, 8'(b), 0);
      for (int a = 8'h40; a < 256; a++) begin
        acc(OP_WR, 8'h03, 8'(a), 0);
        acc(OP_WR, 8'h02, 8'(a ^ (b * 37)), 0);
      end
    end

    cur_req = "R1";
    for (int a = 5; a <= int'(ELST); a++) acc(OP_WR, 8'(a), 8'(a * 7 + 3), 0);
    for (int a = 5; a <= int'(ELST); a++) acc(OP_RD, 8'(a), 0, 0);

    cur_req = "R2";
    acc(OP_WR, 8'h35, 8'hAA, 0); acc(OP_RD, 8'h35, 0, 0);
    acc(OP_SET, 8'h3F, 0, 4);    acc(OP_RD, 8'h3F, 0, 0); acc(OP_RD, 8'h30, 0, 0);

    cur_req = "R3";
    acc(OP_WR, 8'h04, 8'h02, 0);
    acc(OP_RD, 8'h50, 0, 0); acc(OP_WR, 8'h51, 8'h5C, 0); acc(OP_RD, 8'h51, 0, 0);
    acc(OP_WR, 8'h03, 8'h51, 0); acc(OP_RD, 8'h02, 0, 0);
    acc(OP_WR, 8'h04, 8'h00, 0); acc(OP_RD, 8'h02, 0, 0);

    cur_req = "R4";
    acc(OP_WR, 8'h04, 8'h03, 0);
    acc(OP_WR, 8'h01, 8'h60, 0); acc(OP_RD, 8'h00, 0, 0);
    acc(OP_WR, 8'h00, 8'h9E, 0); acc(OP_RD, 8'h60, 0, 0);
    acc(OP_WR, 8'h01, 8'h12, 0); acc(OP_RD, 8'h00, 0, 0);

    cur_req = "R5";
    acc(OP_WR, 8'h03, 8'hC7, 0);
    for (int b = 0; b < NB; b++) begin acc(OP_WR, 8'h04, 8'(b), 0); acc(OP_RD, 8'h02, 0, 0); end
    acc(OP_WR, 8'h03, 8'h10, 0); acc(OP_RD, 8'h02, 0, 0);
    acc(OP_WR, 8'h04, 8'h07, 0); acc(OP_RD, 8'h02, 0, 0);

    cur_req = "R6";
    acc(OP_WR, 8'h03, 8'h70, 0);
    acc(OP_WR, 8'h04, 8'(NB), 0); acc(OP_RD, 8'h02, 0, 0); acc(OP_WR, 8'h02, 8'hFF, 0);
    acc(OP_WR, 8'h04, 8'hFF, 0); acc(OP_RD, 8'h02, 0, 0); acc(OP_SET, 8'h02, 0, 1);
    for (int b = 0; b < NB; b++) begin acc(OP_WR, 8'h04, 8'(b), 0); acc(OP_RD, 8'h02, 0, 0); end

    cur_req = "R7";
    acc(OP_WR, 8'h01, 8'h00, 0); acc(OP_RD, 8'h00, 0, 0); acc(OP_WR, 8'h00, 8'h55, 0);
    acc(OP_RD, 8'h01, 0, 0);
    acc(OP_WR, 8'h01, 8'h02, 0); acc(OP_SET, 8'h00, 0, 3); acc(OP_RD, 8'h00, 0, 0);
    acc(OP_WR, 8'h03, 8'h02, 0); acc(OP_RD, 8'h02, 0, 0); acc(OP_WR, 8'h02, 8'h66, 0);
    acc(OP_WR, 8'h03, 8'h00, 0); acc(OP_CLR, 8'h02, 0, 0); acc(OP_RD, 8'h02, 0, 0);
    acc(OP_RD, 8'h01, 0, 0); acc(OP_RD, 8'h03, 0, 0); acc(OP_RD, 8'h04, 0, 0);

    cur_req = "R8";
    acc(OP_SET, 8'h80, 0, 7); acc(OP_RD, 8'h80, 0, 0);
    acc(OP_CLR, 8'h80, 0, 0); acc(OP_RD, 8'h80, 0, 0);
    acc(OP_WR, 8'h04, 8'h03, 0); acc(OP_WR, 8'h03, 8'hA5, 0);
    acc(OP_CLR, 8'h02, 0, 5); acc(OP_SET, 8'h02, 0, 6); acc(OP_RD, 8'h02, 0, 0);
    acc(OP_SET, 8'h09, 0, 2); acc(OP_CLR, 8'h22, 0, 1); acc(OP_RD, 8'h09, 0, 0); acc(OP_RD, 8'h22, 0, 0);
    acc(OP_CLR, 8'h04, 0, 0); acc(OP_RD, 8'h04, 0, 0);
    acc(OP_RD, 8'h02, 0, 0);

    cur_req = "R11";
    acc(OP_WR, 8'h03, 8'h01, 0); acc(OP_WR, 8'h02, 8'h44, 0); acc(OP_RD, 8'h01, 0, 0);
    acc(OP_WR, 8'h01, 8'h04, 0); acc(OP_SET, 8'h00, 0, 0); acc(OP_RD, 8'h04, 0, 0);
    acc(OP_RD, 8'h00, 0, 0);

    cur_req = "R9";
    idle(); idle();
    acc(OP_RD, 8'h41, 0, 0); idle(); acc(OP_RD, 8'h42, 0, 0); acc(OP_RD, 8'h43, 0, 0);
    idle(); idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule